// File: doc/BRIEF.md
# Dual-Mode SPI Serial Clock Divider

This block derives the serial clock of an SPI master channel from the functional clock. The division ratio comes from one of two schemes, and a single granularity input picks between them. In coarse mode the 4-bit divider field is an exponent, so the ratio is a power of two. In fine mode an 8-bit extension field supplies the upper bits of a 12-bit integer ratio and the same 4-bit field supplies the lower bits. Ratios that do not fit in 12 bits have to use coarse mode.

Besides the serial clock, the block drives two one-cycle strobes for the shift engine. One marks the cycle in which the clock leaves its idle level. The other marks the cycle in which it returns to idle. The polarity input sets the idle level. The divider runs only while enable is high. A period always completes with the ratio that was sampled at its start.

Top module: `spiclk_div`

## Requirements
- R1: With `gran_lin` = 0 the period is 2^`div_sel` functional-clock cycles, from 1 (`div_sel` = 0) to 32768 (`div_sel` = 15).
- R2: With `gran_lin` = 1 the period is `div_ext` × 16 + `div_sel` cycles, a 12-bit value in which `div_ext` forms bits 11:4 and `div_sel` forms bits 3:0.
- R3: A ratio of 1 (linear value 0, linear value 1, or coarse field 0) passes the functional clock straight through. `sclk` equals `clk` XOR `cpol`, and both strobes stay high while enabled.
- R4: For a ratio R ≥ 2, sclk holds its active (non-idle) level for floor(R/2) cycles at the start of each period and its idle level for the remaining cycles. An even R therefore gives a 50% duty cycle, and an odd R gives an active phase one cycle shorter than the idle phase.
- R5: `lead_stb` is high for exactly the cycle in which sclk first shows its active level in a period. `trail_stb` is high for exactly the cycle in which sclk first returns to idle.
- R6: The idle level of `sclk` is `cpol`, and the active level is the inverse of `cpol`.
- R7: While `enable` is low, `sclk` equals `cpol` and `lead_stb` is low. When `enable` is sampled high, the next cycle starts a new period at phase 0, with `sclk` active and `lead_stb` high.
- R8: A change to `gran_lin`, `div_sel` or `div_ext` has no effect until the current period ends. The new ratio applies from the next period boundary.
- R9: After reset `sclk` equals `cpol` and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run the divider |
| gran_lin | input | 1 | 0 = power-of-two ratio, 1 = 12-bit linear ratio |
| div_sel | input | 4 | Exponent (coarse) or ratio bits 3:0 (fine) |
| div_ext | input | 8 | Ratio bits 11:4 in fine mode |
| cpol | input | 1 | Idle level of the serial clock |
| sclk | output | 1 | Serial clock |
| lead_stb | output | 1 | Leading-edge strobe |
| trail_stb | output | 1 | Trailing-edge strobe |

## Verification
The hardest case to reach from the ports is a ratio change that arrives in the middle of a period. The old ratio must hold until the period ends, and the new one must take over exactly at the boundary. The stimulus starts a 6-cycle period, rewrites the field to 4 two cycles in, and checks every later cycle against the old pattern up to cycle 6 and against the new pattern from there on. The slowest coarse ratio, 32768, is run for a full period as well, so that the wide counter and the trailing edge at its midpoint are both observed.

// File: rtl/spiclk_pkg.sv
`timescale 1ns/1ps
package spiclk_pkg;

    typedef enum logic {
        SCALE_POW2   = 1'b0,
        SCALE_LINEAR = 1'b1
    } scale_e;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/spiclk_ratio.sv
`timescale 1ns/1ps
module spiclk_ratio #(
    parameter int DIV_W = 4,
    parameter int EXT_W = 8,
    parameter int CNT_W = 16
) (
    input  logic             gran_lin,
    input  logic [DIV_W-1:0] div_sel,
    input  logic [EXT_W-1:0] div_ext,
    output logic [CNT_W-1:0] ratio
);
    import spiclk_pkg::*;

    localparam int LIN_W = DIV_W + EXT_W;

    scale_e           mode;
    logic [LIN_W-1:0] lin_raw;
    logic [CNT_W-1:0] lin_ratio;
    logic [CNT_W-1:0] pow_ratio;

    assign mode    = scale_e'(gran_lin);
    assign lin_raw = {div_ext, div_sel};

    generate
        if (CNT_W > LIN_W) begin : g_lin_pad
            assign lin_ratio = {{(CNT_W-LIN_W){1'b0}}, lin_raw};
        end else begin : g_lin_fit
            assign lin_ratio = lin_raw[CNT_W-1:0];
        end
    endgenerate

    // Coarse mode: one-hot of the exponent.
    assign pow_ratio = {{(CNT_W-1){1'b0}}, 1'b1} << div_sel;

    always_comb begin
        if (mode == SCALE_LINEAR) begin
            ratio = (lin_ratio == '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : lin_ratio;
        end else begin
            ratio = pow_ratio;
        end
    end

endmodule

// File: rtl/spiclk_phase.sv
`timescale 1ns/1ps
module spiclk_phase #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CNT_W-1:0] ratio_in,
    output logic             run,
    output logic             active,
    output logic             lead,
    output logic             trail,
    output logic             bypass,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] ratio
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] ratio;
        logic             act;
        logic             lead;
        logic             trail;
    } phase_t;

    phase_t st_d, st_q;
    logic   wrap;

    always_comb begin
        st_d       = st_q;
        st_d.lead  = 1'b0;
        st_d.trail = 1'b0;
        wrap       = (st_q.cnt == st_q.ratio - ONE);
        if (!enable) begin
            st_d.run = 1'b0;
            st_d.cnt = '0;
        end else if (!st_q.run || wrap) begin
            // Period boundary: the only point where a new ratio is taken.
            st_d.run   = 1'b1;
            st_d.cnt   = '0;
            st_d.ratio = ratio_in;
        end else begin
            st_d.cnt = st_q.cnt + ONE;
        end
        st_d.act   = st_d.run && (st_d.cnt < (st_d.ratio >> 1));
        st_d.lead  = st_d.act && !st_q.act;
        st_d.trail = !st_d.act && st_q.act;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{run: 1'b0, cnt: '0, ratio: ONE, act: 1'b0,
                      lead: 1'b0, trail: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign run    = st_q.run;
    assign active = st_q.act;
    assign lead   = st_q.lead;
    assign trail  = st_q.trail;
    assign bypass = st_q.run && (st_q.ratio == ONE);
    assign cnt    = st_q.cnt;
    assign ratio  = st_q.ratio;

endmodule

// File: rtl/spiclk_div.sv
`timescale 1ns/1ps
module spiclk_div #(
    parameter int DIV_W = 4,
    parameter int EXT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             gran_lin,
    input  logic [DIV_W-1:0] div_sel,
    input  logic [EXT_W-1:0] div_ext,
    input  logic             cpol,
    output logic             sclk,
    output logic             lead_stb,
    output logic             trail_stb
);
    import spiclk_pkg::*;

    localparam int CNT_W = max_of(2**DIV_W, DIV_W + EXT_W);

    logic [CNT_W-1:0] ratio_new;
    logic [CNT_W-1:0] ratio_cur;
    logic [CNT_W-1:0] cnt_cur;
    logic             run_cur;
    logic             act_cur;
    logic             lead_cur;
    logic             trail_cur;
    logic             bypass_cur;

    spiclk_ratio #(.DIV_W(DIV_W), .EXT_W(EXT_W), .CNT_W(CNT_W)) u_ratio (
        .gran_lin (gran_lin),
        .div_sel  (div_sel),
        .div_ext  (div_ext),
        .ratio    (ratio_new)
    );

    spiclk_phase #(.CNT_W(CNT_W)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .ratio_in (ratio_new),
        .run      (run_cur),
        .active   (act_cur),
        .lead     (lead_cur),
        .trail    (trail_cur),
        .bypass   (bypass_cur),
        .cnt      (cnt_cur),
        .ratio    (ratio_cur)
    );

    // Ratio 1 forwards the functional clock; otherwise the registered phase.
    assign sclk      = bypass_cur ? (clk ^ cpol) : (act_cur ^ cpol);
    assign lead_stb  = bypass_cur | lead_cur;
    assign trail_stb = bypass_cur | trail_cur;

endmodule

// File: rtl/spiclk_div_chk.sv
`timescale 1ns/1ps
module spiclk_div_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             cpol,
    input logic             sclk,
    input logic             lead_stb,
    input logic             trail_stb,
    input logic             bypass,
    input logic             run,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] ratio
);

    p_idle_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(enable) |-> (sclk == cpol) && !lead_stb);

    p_lead_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lead_stb && !bypass) |-> (sclk != cpol));

    p_trail_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (trail_stb && !bypass) |-> (sclk == cpol));

    p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !bypass |-> !(lead_stb && trail_stb));

    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < ratio));

    p_ratio_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && cnt != '0) |-> $stable(ratio));

endmodule

bind spiclk_div spiclk_div_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .cpol      (cpol),
    .sclk      (sclk),
    .lead_stb  (lead_stb),
    .trail_stb (trail_stb),
    .bypass    (bypass_cur),
    .run       (run_cur),
    .cnt       (cnt_cur),
    .ratio     (ratio_cur)
);

// File: tb/sim_spiclk_div.sv
`timescale 1ns/1ps
module sim_spiclk_div;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       gran_lin = 1'b0;
    logic [3:0] div_sel = '0;
    logic [7:0] div_ext = '0;
    logic       cpol = 1'b0;
    logic       sclk, lead_stb, trail_stb;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    spiclk_div u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .gran_lin(gran_lin),
        .div_sel(div_sel), .div_ext(div_ext), .cpol(cpol),
        .sclk(sclk), .lead_stb(lead_stb), .trail_stb(trail_stb)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic begin_run(input logic g, input logic [3:0] d, input logic [7:0] e);
        @(negedge clk);
        gran_lin = g; div_sel = d; div_ext = e; enable = 1'b1;
    endtask

    task automatic end_run();
        @(negedge clk);
        enable = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // Sample k (0-based from the edge that first sees enable) vs the period-R pattern.
    task automatic check_sample(input string req, input int r, input int k);
        int ph = k % r;
        @(posedge clk); #5;
        chk(req, "sclk",  int'(sclk),      int'(((ph < r/2) ? 1'b1 : 1'b0) ^ cpol));
        chk(req, "lead",  int'(lead_stb),  (ph == 0) ? 1 : 0);
        chk(req, "trail", int'(trail_stb), (ph == r/2) ? 1 : 0);
    endtask

    task automatic run_pattern(input string req, input int r, input int n);
        for (int k = 0; k < n; k++) check_sample(req, r, k);
    endtask

    task automatic t_reset();
        #5;
        chk("R9", "sclk after reset", int'(sclk), 0);
        chk("R9", "lead after reset", int'(lead_stb), 0);
        chk("R9", "trail after reset", int'(trail_stb), 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); cpol = 1'b1; #1;
        chk("R6", "idle sclk cpol=1", int'(sclk), 1);
        @(negedge clk); cpol = 1'b0; #1;
        chk("R6", "idle sclk cpol=0", int'(sclk), 0);
    endtask

    task automatic t_linear_even();  // R2 R4: 6
        begin_run(1'b1, 4'd6, 8'd0);
        run_pattern("R2", 6, 18);
        end_run();
    endtask

    task automatic t_linear_odd();   // R4: 5
        begin_run(1'b1, 4'd5, 8'd0);
        run_pattern("R4", 5, 15);
        end_run();
    endtask

    task automatic t_linear_ext();   // R2: ext 1, sel 3 -> 19
        begin_run(1'b1, 4'd3, 8'd1);
        run_pattern("R2", 19, 40);
        end_run();
    endtask

    task automatic t_pow2();         // R1: 2^3 = 8
        begin_run(1'b0, 4'd3, 8'hFF);
        run_pattern("R1", 8, 24);
        end_run();
    endtask

    task automatic t_pow2_max();     // R1: 2^15 = 32768
        begin_run(1'b0, 4'd15, 8'd0);
        run_pattern("R1", 32768, 32770);
        end_run();
    endtask

    task automatic t_gran_switch();  // R1 vs R2 with sel = 2: 4 then 2
        begin_run(1'b0, 4'd2, 8'd0);
        run_pattern("R1", 4, 8);
        end_run();
        begin_run(1'b1, 4'd2, 8'd0);
        run_pattern("R2", 2, 6);
        end_run();
    endtask

    task automatic t_bypass(input logic g, input logic p);  // R3
        @(negedge clk); cpol = p;
        begin_run(g, 4'd0, 8'd0);
        @(posedge clk);
        for (int k = 0; k < 4; k++) begin
            @(posedge clk); #5;
            chk("R3", "sclk clk high", int'(sclk), int'(1'b1 ^ p));
            chk("R3", "lead", int'(lead_stb), 1);
            chk("R3", "trail", int'(trail_stb), 1);
            @(negedge clk); #5;
            chk("R3", "sclk clk low", int'(sclk), int'(p));
        end
        end_run();
        cpol = 1'b0;
    endtask

    task automatic t_cpol();         // R6: ratio 4, inverted
        @(negedge clk); cpol = 1'b1;
        begin_run(1'b1, 4'd4, 8'd0);
        run_pattern("R6", 4, 12);
        end_run();
        cpol = 1'b0;
    endtask

    task automatic t_midchange();    // R8: 6 -> 4 requested in cycle 2
        begin_run(1'b1, 4'd6, 8'd0);
        check_sample("R8", 6, 0);
        check_sample("R8", 6, 1);
        @(negedge clk); div_sel = 4'd4;
        for (int k = 2; k < 6; k++) check_sample("R8", 6, k);
        for (int k = 6; k < 18; k++) check_sample("R8", 4, k - 6);
        end_run();
    endtask

    task automatic t_restart();      // R7: drop mid-period, restart at phase 0
        begin_run(1'b0, 4'd3, 8'd0);
        run_pattern("R7", 8, 2);
        @(negedge clk); enable = 1'b0;
        @(posedge clk); #5;
        chk("R7", "sclk idle after disable", int'(sclk), 0);
        chk("R7", "lead after disable", int'(lead_stb), 0);
        chk("R5", "trail on return to idle", int'(trail_stb), 1);
        @(posedge clk); #5;
        chk("R7", "sclk still idle", int'(sclk), 0);
        chk("R5", "trail single cycle", int'(trail_stb), 0);
        begin_run(1'b0, 4'd3, 8'd0);
        run_pattern("R7", 8, 16);
        end_run();
    endtask

    initial begin
        t_reset();
        t_linear_even();
        t_linear_odd();
        t_linear_ext();
        t_pow2();
        t_gran_switch();
        t_bypass(1'b1, 1'b0);
        t_bypass(1'b0, 1'b1);
        t_cpol();
        t_midchange();
        t_restart();
        t_pow2_max();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        #(20 * 190000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule